// File: doc/BRIEF.md
# PTP time-of-day counter with fractional increment

This block keeps a precision time-of-day value for a network timestamping path. The value is a 48-bit seconds count and a nanoseconds count that stays below one billion. On every cycle of its reference clock the counter advances by a programmable step. The step is an 8-bit whole-nanosecond amount plus a 24-bit binary fraction of a nanosecond. The fraction is summed into an accumulator, and each overflow of that accumulator adds one extra nanosecond. With this scheme a reference clock whose period is not a whole number of nanoseconds still tracks true time.

Software reaches the counter through a flat 32-bit write port and a separate read port. Through them it can load the nanoseconds, load the seconds in two words, program the step, and apply a one-shot signed correction. The seconds count is loaded only when the low word is written, and that load uses the high word written earlier. A new fraction is held in a staging register and is copied into the live step only when the whole-nanosecond step register is written, so the two parts of the step change on the same edge. Reads return live values. The full time is also driven on output ports for the logic that captures timestamps.

Register map (3-bit address). 0 nanoseconds. 1 seconds bits [31:0]. 2 seconds bits [47:32]. 3 whole-nanosecond step. 4 staged fraction. 5 one-shot adjust.

Top module: `ptp_tod_counter`

## Requirements
- R1: While reset is low, and after it is released, nanoseconds, seconds, the step, the staged fraction and the accumulator are all zero. With a zero step the time does not move.
- R2: On each clock with no write to address 0, the sum is formed as nanoseconds + whole step + carry, where the carry is the overflow out of bit 24 of a 24-bit accumulator that adds the fractional step on every clock.
- R3: When that sum reaches 1,000,000,000, one billion is taken away from the nanoseconds and seconds go up by one. Nanoseconds never read 1,000,000,000 or more.
- R4: A write to address 4 takes fraction bits [23:8] from data bits [15:0] and fraction bits [7:0] from data bits [31:24]. The value is only staged and has no effect on the running step. It becomes the live fraction on the edge of the next write to address 3, together with the new whole step taken from data bits [7:0].
- R5: A write to address 2 holds data bits [15:0] and leaves seconds unchanged. A write to address 1 loads seconds with {held high word, data[31:0]}, and this overrides any carry in the same cycle.
- R6: A write to address 0 loads nanoseconds with data bits [29:0] in place of that cycle's step. Seconds receive no carry in that cycle.
- R7: A write to address 5 adds (data bit 31 = 0) or subtracts (bit 31 = 1) the magnitude in data bits [29:0] once, on top of that cycle's step. Bit 30 is ignored. A result below zero adds one billion and decrements seconds. A result of one billion or more wraps and increments seconds. A magnitude of zero leaves only the normal step.
- R8: The read port returns, as live values, the following. Address 0: nanoseconds. Address 1: seconds [31:0]. Address 2: seconds [47:32], zero-extended. Address 3: the whole step. Address 4: the staged fraction in the write layout. Addresses 5 to 7: zero.
- R9: Seconds wrap from 2^48-1 to 0 when a nanosecond carry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register address of the read |
| rd_data | output | 32 | Live read data for rd_addr |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
The bench covers several cases where a wrong design would give a visibly wrong result:
- It runs a fractional step that carries only every few cycles. A design that dropped or doubled the accumulator carry would drift away from the model within a handful of cycles.
- It parks nanoseconds just below one billion and also runs seconds up to their 48-bit limit. An off-by-one wrap compare or a missing seconds carry shows up on the exact edge.
- It writes the staged fraction while a step is running and checks that the time keeps its old rate until the whole-step write.
- It applies subtract adjusts that cross zero, add adjusts that cross one billion, and zero-magnitude adjusts. These expose a missing borrow, a stuck adjust or a sign taken from the wrong bit.

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int SEC_W = 48,
  parameter int INC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [29:0]       tod_ns
);
  localparam int HI_W = SEC_W - 32;
  localparam int FR_W = 24;
  localparam logic signed [32:0] BILLION = 33'sd1000000000;
  localparam logic [2:0] A_NS = 3'd0, A_SLO = 3'd1, A_SHI = 3'd2,
                         A_INC = 3'd3, A_FRAC = 3'd4, A_ADJ = 3'd5;

  logic [29:0]      ns_q;
  logic [SEC_W-1:0] sec_q;
  logic [FR_W-1:0]  frac_q, inc_frac_q, stage_q;
  logic [INC_W-1:0] inc_ns_q;
  logic [HI_W-1:0]  hi_hold_q;

  wire wr_ns   = wr_en && (wr_addr == A_NS);
  wire wr_slo  = wr_en && (wr_addr == A_SLO);
  wire wr_shi  = wr_en && (wr_addr == A_SHI);
  wire wr_inc  = wr_en && (wr_addr == A_INC);
  wire wr_frac = wr_en && (wr_addr == A_FRAC);
  wire wr_adj  = wr_en && (wr_addr == A_ADJ);

  logic [FR_W:0] frac_sum;
  assign frac_sum = {1'b0, frac_q} + {1'b0, inc_frac_q};

  logic signed [32:0] adj_mag, adj_val, ns_raw, ns_wrap;
  logic ovf, unf;
  assign adj_mag = $signed({3'b000, wr_data[29:0]});
  assign adj_val = !wr_adj ? 33'sd0 : (wr_data[31] ? -adj_mag : adj_mag);
  assign ns_raw  = $signed({3'b000, ns_q})
                 + $signed({{(33-INC_W){1'b0}}, inc_ns_q})
                 + $signed({32'b0, frac_sum[FR_W]})
                 + adj_val;
  assign ovf     = ns_raw >= BILLION;
  assign unf     = ns_raw < 33'sd0;
  assign ns_wrap = ovf ? ns_raw - BILLION : (unf ? ns_raw + BILLION : ns_raw);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_q       <= '0;
      sec_q      <= '0;
      frac_q     <= '0;
      inc_frac_q <= '0;
      stage_q    <= '0;
      inc_ns_q   <= '0;
      hi_hold_q  <= '0;
    end else begin
      frac_q <= frac_sum[FR_W-1:0];
      ns_q   <= wr_ns ? wr_data[29:0] : ns_wrap[29:0];
      if (wr_slo)
        sec_q <= {hi_hold_q, wr_data};
      else if (!wr_ns && ovf)
        sec_q <= sec_q + 1'b1;
      else if (!wr_ns && unf)
        sec_q <= sec_q - 1'b1;
      if (wr_shi)
        hi_hold_q <= wr_data[HI_W-1:0];
      if (wr_inc) begin
        inc_ns_q   <= wr_data[INC_W-1:0];
        inc_frac_q <= stage_q;
      end
      if (wr_frac)
        stage_q <= {wr_data[15:0], wr_data[31:24]};
    end
  end

  always_comb begin
    case (rd_addr)
      A_NS:    rd_data = {2'b00, ns_q};
      A_SLO:   rd_data = sec_q[31:0];
      A_SHI:   rd_data = {{(32-HI_W){1'b0}}, sec_q[SEC_W-1:32]};
      A_INC:   rd_data = {{(32-INC_W){1'b0}}, inc_ns_q};
      A_FRAC:  rd_data = {stage_q[7:0], 8'b0, stage_q[23:8]};
      default: rd_data = '0;
    endcase
  end

  assign tod_sec = sec_q;
  assign tod_ns  = ns_q;
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk #(
  parameter int SEC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic [SEC_W-1:0] tod_sec,
  input logic [29:0]      tod_ns,
  input logic [23:0]      inc_frac
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (tod_ns == '0 && tod_sec == '0));

  assert_ns_below_billion_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tod_ns < 30'd1000000000);

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd1) |=>
      (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 1'b1 ||
       tod_sec == $past(tod_sec) - 1'b1));

  assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4) |=> $stable(inc_frac));

  assert_sec_low_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> tod_sec[31:0] == $past(wr_data));

  assert_ns_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> tod_ns == $past(wr_data[29:0]));
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(.SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tod_sec(tod_sec), .tod_ns(tod_ns),
  .inc_frac(inc_frac_q)
);

// File: tb/sim_ptp_tod_counter.sv
module sim_ptp_tod_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  ptp_tod_counter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  localparam longint SEC_MASK = (64'sd1 <<< 48) - 1;
  localparam longint BIL = 64'sd1000000000;

  int checks = 0, fails = 0;
  string req = "R1";
  bit started = 0, done = 0;
  longint m_ns = 0, m_sec = 0, m_frac = 0, m_incns = 0, m_incfrac = 0;
  longint m_stage = 0, m_hold = 0;
  longint sum, t, sn, mag;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_ns = 0; m_sec = 0; m_frac = 0; m_incns = 0;
      m_incfrac = 0; m_stage = 0; m_hold = 0;
    end else begin
      sum = m_frac + m_incfrac;
      t = m_ns + m_incns + (sum >> 24);
      m_frac = sum & 64'hFFFFFF;
      sn = m_sec;
      if (wr_en && wr_addr == 3'd5) begin
        mag = longint'(wr_data[29:0]);
        t = wr_data[31] ? t - mag : t + mag;
      end
      if (t >= BIL) begin t = t - BIL; sn = sn + 1; end
      else if (t < 0) begin t = t + BIL; sn = sn - 1; end
      if (wr_en && wr_addr == 3'd0) begin t = longint'(wr_data[29:0]); sn = m_sec; end
      if (wr_en && wr_addr == 3'd1) sn = (m_hold << 32) | longint'(wr_data);
      if (wr_en && wr_addr == 3'd2) m_hold = longint'(wr_data[15:0]);
      if (wr_en && wr_addr == 3'd3) begin m_incns = longint'(wr_data[7:0]); m_incfrac = m_stage; end
      if (wr_en && wr_addr == 3'd4)
        m_stage = (longint'(wr_data[15:0]) << 8) | longint'(wr_data[31:24]);
      m_ns = t;
      m_sec = sn & SEC_MASK;
    end
  end

  always @(posedge clk) begin
    #3 rd_addr = (rd_addr == 3'd7) ? 3'd0 : rd_addr + 3'd1;
  end

  function automatic longint exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ns;
      3'd1: return m_sec & 64'hFFFFFFFF;
      3'd2: return m_sec >> 32;
      3'd3: return m_incns;
      3'd4: return ((m_stage & 255) << 24) | (m_stage >> 8);
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (longint'(tod_ns) != m_ns) begin
        fails++;
        $display("FAIL %s nanoseconds: actual %0d expected %0d", req, tod_ns, m_ns);
      end
      checks++;
      if (longint'(tod_sec) != m_sec) begin
        fails++;
        $display("FAIL %s seconds: actual %0h expected %0h", req, tod_sec, m_sec);
      end
      checks++;
      if (longint'(rd_data) != exp_rd(rd_addr)) begin
        fails++;
        $display("FAIL R8 read addr %0d: actual %0h expected %0h", rd_addr, rd_data, exp_rd(rd_addr));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    req = "R1"; idle(10);
    req = "R4"; wr(3'd4, 32'h0000_4000); idle(6);
    req = "R2"; wr(3'd3, 32'd8); idle(24);
    req = "R4"; wr(3'd4, 32'h5500_5555); idle(6);
    req = "R2"; wr(3'd3, 32'd20); idle(30);
    req = "R3"; wr(3'd0, 32'd999_999_900); idle(20);
    req = "R5"; wr(3'd0, 32'd0); wr(3'd2, 32'h0000_1234); idle(3);
    wr(3'd1, 32'h89AB_CDEF); idle(5);
    req = "R6"; wr(3'd0, 32'd500); idle(4);
    wr(3'd0, 32'hC000_0100); idle(4);
    req = "R7"; wr(3'd0, 32'd10); wr(3'd5, 32'h8000_0064); idle(4);
    wr(3'd0, 32'd999_999_000); wr(3'd5, 32'd5000); idle(4);
    wr(3'd5, 32'd0); idle(2);
    wr(3'd5, 32'h8000_0000); idle(2);
    wr(3'd5, 32'h4000_0010); idle(2);
    wr(3'd5, 32'h8000_1000); idle(4);
    req = "R9"; wr(3'd0, 32'd0); wr(3'd2, 32'h0000_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'd999_999_950); idle(20);
    req = "R8"; idle(16);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL %s watchdog: actual hung expected finished", req);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule